// File: doc/BRIEF.md
# Task state save and back-link write sequencer

This block performs the write-back half of a hardware task switch. When started, it takes a snapshot of the outgoing task's program counter, flags, general registers, segment selectors and local-descriptor-table selector. It also captures the outgoing and incoming task-state segment bases, the segment format (32-bit or 16-bit), the outgoing task-register selector and the cause of the switch. It then issues an ordered series of word and dword writes on a simple request/acknowledge write port. These writes store the outgoing state into the current task-state segment. For causes that nest tasks, one more write places the outgoing task selector into the link field of the incoming segment.

When the last write is acknowledged, the block pulses `done` for one cycle. During that pulse it presents three decisions for the surrounding switch logic: clear the busy bit in the outgoing descriptor, set the busy bit in the incoming descriptor, and set the nested-task bit in the flags image that will be loaded. Loading the new state and checking descriptors are handled elsewhere.

Top module: `tss_save_seq`

## Requirements
- R1: A `start` sampled while idle captures every input. `mem_req` rises two cycles after that edge. For a 32-bit segment (`tss32`=1), the saves go in this order: program counter as a dword at base+32, flags as a dword at base+36, general register i as a dword at base+40+4i (i = 0..7), segment selector i zero-extended to a dword at base+72+4i (i = 0..5), and finally the LDT selector as a word at base+96.
- R2: For a 16-bit segment (`tss32`=0), the saves go in this order, all as words: low half of the program counter at base+14, low flags half at base+16, low half of general register i at base+18+2i, segment selector i at base+34+2i (i = 0..3), and the LDT selector at base+42. No dword write is issued.
- R3: A word write carries its value in `mem_wdata[15:0]` with bits 31:16 zero and `mem_dword`=0. A dword write has `mem_dword`=1. Addresses are formed as base plus offset, modulo 2^32.
- R4: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_wdata` and `mem_dword` hold steady. Each acknowledged cycle retires exactly one write.
- R5: Cause encoding is 0 = jump, 1 = call, 2 = interrupt, 3 = return-from-interrupt. For call and interrupt, one more word write follows the saves: `tr_sel` to `new_base`+0. For jump and return-from-interrupt, no such write is issued.
- R6: `done` is high for exactly one cycle, in the cycle after the final acknowledge, with `mem_req` low.
- R7: During `done`, `clr_old_busy` is 1 for jump and return-from-interrupt, `set_new_busy` is 1 for call, interrupt and jump, and `set_nt` is 1 for call and interrupt. Outside `done`, all three are 0.
- R8: `busy` is high from the cycle after an accepted start until `done`. A `start` raised while busy has no effect on the writes or on the decisions of the switch in progress.
- R9: After reset, `busy`, `mem_req`, `done` and the three decision outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a save sequence (ignored while busy) |
| cause | input | 2 | Switch cause: 0 jump, 1 call, 2 interrupt, 3 return-from-interrupt |
| tss32 | input | 1 | 1 = 32-bit segment format, 0 = 16-bit |
| cur_base | input | 32 | Base address of the outgoing task-state segment |
| new_base | input | 32 | Base address of the incoming task-state segment |
| tr_sel | input | 16 | Outgoing task-register selector |
| eip | input | 32 | Outgoing program counter |
| eflags | input | 32 | Outgoing flags |
| gpr_flat | input | 256 | Eight general registers, register i at bits 32i+31:32i |
| seg_flat | input | 96 | Six segment selectors, selector i at bits 16i+15:16i |
| ldtr_sel | input | 16 | Outgoing LDT selector |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Write request |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Write data |
| mem_dword | output | 1 | 1 = dword write, 0 = word write |
| mem_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| clr_old_busy | output | 1 | Clear busy bit of outgoing descriptor (valid with done) |
| set_new_busy | output | 1 | Set busy bit of incoming descriptor (valid with done) |
| set_nt | output | 1 | Set nested-task bit in incoming flags (valid with done) |

## Verification
The hardest case to reach is a second `start`, carrying different cause, bases and register values, that arrives while a write is stalled waiting for acknowledge. The bench reaches it by holding `mem_ack` low for several cycles during one write. While the write is stalled, it pulses `start` and changes every data input. It then checks that the remaining writes and the final decisions still match the first request's snapshot. Long acknowledge stalls on some table rows also exercise the hold rule at many write positions. One row places the outgoing base just below the top of the address space, so the offsets wrap.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [1:0] {
    CAUSE_JMP  = 2'd0,
    CAUSE_CALL = 2'd1,
    CAUSE_INTR = 2'd2,
    CAUSE_IRET = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    SRC_PC    = 3'd0,
    SRC_FLAGS = 3'd1,
    SRC_GPR   = 3'd2,
    SRC_SEG   = 3'd3,
    SRC_LDT   = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_SAVE = 2'd2,
    ST_LINK = 2'd3
  } seq_state_e;

  localparam int OFFW = 8;

  // Segment layout, wide format (byte offsets)
  localparam int W_OFF_PC    = 32;
  localparam int W_OFF_FLAGS = 36;
  localparam int W_OFF_GPR   = 40;
  localparam int W_OFF_SEG   = 72;
  localparam int W_OFF_LDT   = 96;

  // Segment layout, narrow format (byte offsets)
  localparam int N_OFF_PC    = 14;
  localparam int N_OFF_FLAGS = 16;
  localparam int N_OFF_GPR   = 18;
  localparam int N_OFF_SEG   = 34;
  localparam int N_OFF_LDT   = 42;

endpackage

// File: rtl/tss_step_map.sv
module tss_step_map
  import tss_pkg::*;
#(
  parameter int NGPR   = 8,
  parameter int NSEG32 = 6,
  parameter int NSEG16 = 4,
  parameter int IDXW   = 5
) (
  input  logic            wide,
  input  logic [IDXW-1:0] idx,
  output src_e            src,
  output logic [IDXW-1:0] sub,
  output logic [OFFW-1:0] off,
  output logic            dword,
  output logic            last
);

  always_comb begin
    int j;
    int nseg;
    int s;
    j    = int'(idx);
    nseg = wide ? NSEG32 : NSEG16;
    s    = 0;
    if (j == 0) begin
      src = SRC_PC;
    end else if (j == 1) begin
      src = SRC_FLAGS;
    end else if (j < 2 + NGPR) begin
      src = SRC_GPR;
      s   = j - 2;
    end else if (j < 2 + NGPR + nseg) begin
      src = SRC_SEG;
      s   = j - 2 - NGPR;
    end else begin
      src = SRC_LDT;
    end

    case (src)
      SRC_PC:    off = wide ? OFFW'(W_OFF_PC)          : OFFW'(N_OFF_PC);
      SRC_FLAGS: off = wide ? OFFW'(W_OFF_FLAGS)       : OFFW'(N_OFF_FLAGS);
      SRC_GPR:   off = wide ? OFFW'(W_OFF_GPR + 4 * s) : OFFW'(N_OFF_GPR + 2 * s);
      SRC_SEG:   off = wide ? OFFW'(W_OFF_SEG + 4 * s) : OFFW'(N_OFF_SEG + 2 * s);
      default:   off = wide ? OFFW'(W_OFF_LDT)         : OFFW'(N_OFF_LDT);
    endcase

    last  = (src == SRC_LDT);
    dword = wide && !last;
    sub   = IDXW'(s);
  end

endmodule

// File: rtl/tss_src_mux.sv
module tss_src_mux
  import tss_pkg::*;
#(
  parameter int NGPR   = 8,
  parameter int NSEG32 = 6,
  parameter int IDXW   = 5
) (
  input  src_e                 src,
  input  logic [IDXW-1:0]      sub,
  input  logic                 wide,
  input  logic [31:0]          pc,
  input  logic [31:0]          flags,
  input  logic [NGPR*32-1:0]   gprs,
  input  logic [NSEG32*16-1:0] segs,
  input  logic [15:0]          ldt,
  output logic [31:0]          wdata
);

  logic [31:0] gsel;
  logic [15:0] ssel;

  always_comb begin
    gsel = gprs[int'(sub)*32 +: 32];
    ssel = segs[int'(sub)*16 +: 16];
    case (src)
      SRC_PC:    wdata = wide ? pc    : {16'h0, pc[15:0]};
      SRC_FLAGS: wdata = wide ? flags : {16'h0, flags[15:0]};
      SRC_GPR:   wdata = wide ? gsel  : {16'h0, gsel[15:0]};
      SRC_SEG:   wdata = {16'h0, ssel};
      default:   wdata = {16'h0, ldt};
    endcase
  end

endmodule

// File: rtl/tss_cause_policy.sv
module tss_cause_policy
  import tss_pkg::*;
(
  input  cause_e cause,
  output logic   need_link,
  output logic   clr_old,
  output logic   set_new,
  output logic   set_nt
);

  always_comb begin
    need_link = 1'b0;
    clr_old   = 1'b0;
    set_new   = 1'b0;
    set_nt    = 1'b0;
    case (cause)
      CAUSE_CALL, CAUSE_INTR: begin
        need_link = 1'b1;
        set_new   = 1'b1;
        set_nt    = 1'b1;
      end
      CAUSE_JMP: begin
        clr_old = 1'b1;
        set_new = 1'b1;
      end
      default: begin
        clr_old = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/tss_save_seq.sv
module tss_save_seq
  import tss_pkg::*;
#(
  parameter int NGPR   = 8,
  parameter int NSEG32 = 6,
  parameter int NSEG16 = 4,
  parameter int AW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           cause,
  input  logic                 tss32,
  input  logic [AW-1:0]        cur_base,
  input  logic [AW-1:0]        new_base,
  input  logic [15:0]          tr_sel,
  input  logic [31:0]          eip,
  input  logic [31:0]          eflags,
  input  logic [NGPR*32-1:0]   gpr_flat,
  input  logic [NSEG32*16-1:0] seg_flat,
  input  logic [15:0]          ldtr_sel,
  output logic                 busy,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  output logic [31:0]          mem_wdata,
  output logic                 mem_dword,
  input  logic                 mem_ack,
  output logic                 done,
  output logic                 clr_old_busy,
  output logic                 set_new_busy,
  output logic                 set_nt
);

  localparam int NSTEP = 2 + NGPR + NSEG32 + 1;
  localparam int IDXW  = $clog2(NSTEP + 1);

  seq_state_e           st;
  logic [IDXW-1:0]      idx;
  logic                 last_q;
  logic                 wide_q;
  cause_e               cause_q;
  logic [AW-1:0]        cur_base_q;
  logic [AW-1:0]        new_base_q;
  logic [15:0]          tr_q;
  logic [31:0]          pc_q;
  logic [31:0]          flags_q;
  logic [NGPR*32-1:0]   gpr_q;
  logic [NSEG32*16-1:0] seg_q;
  logic [15:0]          ldt_q;

  logic [IDXW-1:0] map_idx;
  src_e            map_src;
  logic [IDXW-1:0] map_sub;
  logic [OFFW-1:0] map_off;
  logic            map_dword;
  logic            map_last;
  logic [31:0]     map_data;
  logic            pol_link;
  logic            pol_clr;
  logic            pol_set;
  logic            pol_nt;

  assign map_idx = (st == ST_PREP) ? '0 : idx + 1'b1;
  assign busy    = (st != ST_IDLE);

  tss_step_map #(
    .NGPR(NGPR), .NSEG32(NSEG32), .NSEG16(NSEG16), .IDXW(IDXW)
  ) u_map (
    .wide (wide_q),
    .idx  (map_idx),
    .src  (map_src),
    .sub  (map_sub),
    .off  (map_off),
    .dword(map_dword),
    .last (map_last)
  );

  tss_src_mux #(
    .NGPR(NGPR), .NSEG32(NSEG32), .IDXW(IDXW)
  ) u_mux (
    .src  (map_src),
    .sub  (map_sub),
    .wide (wide_q),
    .pc   (pc_q),
    .flags(flags_q),
    .gprs (gpr_q),
    .segs (seg_q),
    .ldt  (ldt_q),
    .wdata(map_data)
  );

  tss_cause_policy u_pol (
    .cause    (cause_q),
    .need_link(pol_link),
    .clr_old  (pol_clr),
    .set_new  (pol_set),
    .set_nt   (pol_nt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      idx          <= '0;
      last_q       <= 1'b0;
      wide_q       <= 1'b0;
      cause_q      <= CAUSE_JMP;
      cur_base_q   <= '0;
      new_base_q   <= '0;
      tr_q         <= '0;
      pc_q         <= '0;
      flags_q      <= '0;
      gpr_q        <= '0;
      seg_q        <= '0;
      ldt_q        <= '0;
      mem_req      <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_dword    <= 1'b0;
      done         <= 1'b0;
      clr_old_busy <= 1'b0;
      set_new_busy <= 1'b0;
      set_nt       <= 1'b0;
    end else begin
      done         <= 1'b0;
      clr_old_busy <= 1'b0;
      set_new_busy <= 1'b0;
      set_nt       <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st         <= ST_PREP;
            idx        <= '0;
            wide_q     <= tss32;
            cause_q    <= cause_e'(cause);
            cur_base_q <= cur_base;
            new_base_q <= new_base;
            tr_q       <= tr_sel;
            pc_q       <= eip;
            flags_q    <= eflags;
            gpr_q      <= gpr_flat;
            seg_q      <= seg_flat;
            ldt_q      <= ldtr_sel;
          end
        end
        ST_PREP: begin
          st        <= ST_SAVE;
          idx       <= '0;
          mem_req   <= 1'b1;
          mem_addr  <= cur_base_q + AW'(map_off);
          mem_wdata <= map_data;
          mem_dword <= map_dword;
          last_q    <= map_last;
        end
        ST_SAVE: begin
          if (mem_ack) begin
            if (!last_q) begin
              idx       <= map_idx;
              mem_addr  <= cur_base_q + AW'(map_off);
              mem_wdata <= map_data;
              mem_dword <= map_dword;
              last_q    <= map_last;
            end else if (pol_link) begin
              st        <= ST_LINK;
              mem_addr  <= new_base_q;
              mem_wdata <= {16'h0, tr_q};
              mem_dword <= 1'b0;
            end else begin
              st           <= ST_IDLE;
              mem_req      <= 1'b0;
              done         <= 1'b1;
              clr_old_busy <= pol_clr;
              set_new_busy <= pol_set;
              set_nt       <= pol_nt;
            end
          end
        end
        default: begin
          if (mem_ack) begin
            st           <= ST_IDLE;
            mem_req      <= 1'b0;
            done         <= 1'b1;
            clr_old_busy <= pol_clr;
            set_new_busy <= pol_set;
            set_nt       <= pol_nt;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/tss_save_seq_chk.sv
module tss_save_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_dword,
  input logic          mem_ack,
  input logic          wide_q,
  input logic          done,
  input logic          clr_old_busy,
  input logic          set_new_busy,
  input logic          set_nt
);

  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_dword));

  a_r2_narrow_no_dword: assert property (@(posedge clk) disable iff (rst)
    mem_req && !wide_q |-> !mem_dword);

  a_r3_word_upper_zero: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_dword |-> mem_wdata[31:16] == 16'h0);

  a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req && !busy);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_decisions_with_done: assert property (@(posedge clk) disable iff (rst)
    (clr_old_busy || set_new_busy || set_nt) |-> done);

  a_r7_nt_needs_busy_set: assert property (@(posedge clk) disable iff (rst)
    set_nt |-> set_new_busy && !clr_old_busy);

  a_r8_req_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

endmodule

bind tss_save_seq tss_save_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_dword   (mem_dword),
  .mem_ack     (mem_ack),
  .wide_q      (wide_q),
  .done        (done),
  .clr_old_busy(clr_old_busy),
  .set_new_busy(set_new_busy),
  .set_nt      (set_nt)
);

// File: tb/tb_tss_save_seq.sv
`timescale 1ns/1ps
module tb_tss_save_seq;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   cause = 2'd0;
  logic         tss32 = 1'b0;
  logic [31:0]  cur_base = '0;
  logic [31:0]  new_base = '0;
  logic [15:0]  tr_sel = '0;
  logic [31:0]  eip = '0;
  logic [31:0]  eflags = '0;
  logic [255:0] gpr_flat = '0;
  logic [95:0]  seg_flat = '0;
  logic [15:0]  ldtr_sel = '0;
  logic         mem_ack = 1'b0;
  logic         busy, mem_req, mem_dword, done, clr_old_busy, set_new_busy, set_nt;
  logic [31:0]  mem_addr, mem_wdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tss_save_seq dut (
    .clk(clk), .rst(rst), .start(start), .cause(cause), .tss32(tss32),
    .cur_base(cur_base), .new_base(new_base), .tr_sel(tr_sel), .eip(eip),
    .eflags(eflags), .gpr_flat(gpr_flat), .seg_flat(seg_flat), .ldtr_sel(ldtr_sel),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_dword(mem_dword), .mem_ack(mem_ack), .done(done),
    .clr_old_busy(clr_old_busy), .set_new_busy(set_new_busy), .set_nt(set_nt)
  );

  localparam int NV = 8;
  localparam int V_CAUSE [NV] = '{0, 1, 2, 3, 1, 0, 3, 2};
  localparam int V_WIDE  [NV] = '{1, 1, 1, 1, 0, 0, 0, 0};
  localparam logic [31:0] V_CB [NV] = '{32'h0001_0000, 32'h0002_0400, 32'hFFFF_FFF0, 32'h0004_1000,
                                        32'h0000_8000, 32'h0000_9100, 32'hFFFF_FFE0, 32'h0012_3400};
  localparam logic [31:0] V_NB [NV] = '{32'h0005_0000, 32'h0006_0800, 32'h0007_0000, 32'h0008_0000,
                                        32'h0000_A000, 32'h0000_B000, 32'h0000_C000, 32'h00AB_CD00};
  localparam int V_DLY   [NV] = '{0, 1, 3, 0, 2, 0, 1, 4};

  function automatic logic [31:0] rv(input logic [31:0] s, input int c);
    return s * 32'd2654435 + 32'h0101_0000 * c + c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic drive_inputs(input int c, input bit w, input logic [31:0] cb,
                              input logic [31:0] nb, input logic [31:0] s);
    cause    = 2'(c);
    tss32    = w;
    cur_base = cb;
    new_base = nb;
    tr_sel   = rv(s, 21)[15:0];
    eip      = rv(s, 1);
    eflags   = rv(s, 2);
    for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = rv(s, 3 + i);
    for (int i = 0; i < 6; i++) seg_flat[i*16 +: 16] = rv(s, 11 + i)[15:0];
    ldtr_sel = rv(s, 20)[15:0];
  endtask

  // Expected write k: returns {dword, addr, data}
  task automatic exp_write(input int c, input bit w, input logic [31:0] cb, input logic [31:0] nb,
                           input logic [31:0] s, input int k,
                           output logic [31:0] ea, output logic [31:0] ed, output logic edw);
    int nsave;
    nsave = w ? 17 : 15;
    if (k >= nsave) begin
      ea = nb; ed = {16'h0, rv(s, 21)[15:0]}; edw = 1'b0;
    end else if (w) begin
      edw = 1'b1;
      if (k == 0)       begin ea = cb + 32;             ed = rv(s, 1); end
      else if (k == 1)  begin ea = cb + 36;             ed = rv(s, 2); end
      else if (k < 10)  begin ea = cb + 40 + 4*(k-2);   ed = rv(s, 3 + k - 2); end
      else if (k < 16)  begin ea = cb + 72 + 4*(k-10);  ed = {16'h0, rv(s, 11 + k - 10)[15:0]}; end
      else              begin ea = cb + 96;             ed = {16'h0, rv(s, 20)[15:0]}; edw = 1'b0; end
    end else begin
      edw = 1'b0;
      if (k == 0)       begin ea = cb + 14;             ed = {16'h0, rv(s, 1)[15:0]}; end
      else if (k == 1)  begin ea = cb + 16;             ed = {16'h0, rv(s, 2)[15:0]}; end
      else if (k < 10)  begin ea = cb + 18 + 2*(k-2);   ed = {16'h0, rv(s, 3 + k - 2)[15:0]}; end
      else if (k < 14)  begin ea = cb + 34 + 2*(k-10);  ed = {16'h0, rv(s, 11 + k - 10)[15:0]}; end
      else              begin ea = cb + 42;             ed = {16'h0, rv(s, 20)[15:0]}; end
    end
  endtask

  task automatic run_switch(input int c, input bit w, input logic [31:0] cb, input logic [31:0] nb,
                            input logic [31:0] s, input int dly, input bit inject);
    int nw;
    logic [31:0] ea, ed;
    logic edw;
    bit link;
    link = (c == 1) || (c == 2);
    nw = (w ? 17 : 15) + (link ? 1 : 0);
    @(negedge clk);
    drive_inputs(c, w, cb, nb, s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", 32'(busy), 1);
    chk(mem_req == 1'b0, "R1 no request yet", 32'(mem_req), 0);
    @(negedge clk);
    chk(mem_req == 1'b1, "R1 request two cycles after start", 32'(mem_req), 1);
    for (int k = 0; k < nw; k++) begin
      exp_write(c, w, cb, nb, s, k, ea, ed, edw);
      chk(mem_req == 1'b1, (k >= nw - 1 && link) ? "R5 link request" : "R4 request present", 32'(mem_req), 1);
      chk(mem_addr == ea, link && k == nw - 1 ? "R5 link address" : (w ? "R1 address" : "R2 address"), mem_addr, ea);
      chk(mem_wdata == ed, w ? "R1 data" : "R2 data", mem_wdata, ed);
      chk(mem_dword == edw, "R3 size", 32'(mem_dword), 32'(edw));
      for (int d = 0; d < dly; d++) begin
        if (inject && k == 3 && d == 0) begin
          drive_inputs((c + 1) % 4, !w, cb ^ 32'h00F0_0000, nb ^ 32'h0F00_0000, s ^ 32'h5A5A_5A5A);
          start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk(mem_req == 1'b1 && mem_addr == ea && mem_wdata == ed, "R4 held while stalled", mem_addr, ea);
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
    end
    chk(done == 1'b1, "R6 done after last ack", 32'(done), 1);
    chk(mem_req == 1'b0, "R6 no request with done", 32'(mem_req), 0);
    chk(clr_old_busy == (c == 0 || c == 3), "R7 clear old busy", 32'(clr_old_busy), 32'(c == 0 || c == 3));
    chk(set_new_busy == (c != 3), "R7 set new busy", 32'(set_new_busy), 32'(c != 3));
    chk(set_nt == link, "R7 nested flag", 32'(set_nt), 32'(link));
    chk(busy == 1'b0, "R8 idle at done", 32'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0 && set_nt == 1'b0 && clr_old_busy == 1'b0 && set_new_busy == 1'b0,
        "R6 done single cycle", 32'(done), 0);
    chk(mem_req == 1'b0, "R5 no extra write", 32'(mem_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state while held in reset
    chk(busy == 1'b0 && mem_req == 1'b0, "R9 reset idle", {30'h0, busy, mem_req}, 0);
    chk(done == 1'b0 && clr_old_busy == 1'b0 && set_new_busy == 1'b0 && set_nt == 1'b0,
        "R9 reset decisions", {28'h0, done, clr_old_busy, set_new_busy, set_nt}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after reset", 32'(busy), 0);

    for (int v = 0; v < NV; v++)
      run_switch(V_CAUSE[v], V_WIDE[v] != 0, V_CB[v], V_NB[v], 32'h1000 + 32'(v) * 32'h3F1, V_DLY[v], 1'b0);

    // R8: start raised during a stalled write is ignored
    run_switch(1, 1'b1, 32'h0030_0000, 32'h0031_0000, 32'hBEEF_0001, 3, 1'b1);
    run_switch(3, 1'b0, 32'h0040_0000, 32'h0041_0000, 32'hCAFE_0002, 2, 1'b1);

    // R3: address wrap on narrow format at top of space
    run_switch(2, 1'b0, 32'hFFFF_FFFC, 32'hFFFF_FFFE, 32'h7777_0003, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'(checks), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule